// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Bank

This block holds operations waiting for one class of functional unit. An operation comes in with two source operands. Each operand is either a finished value or the tag of the operation that will produce it. It also carries the reorder-buffer number of its destination. Entries whose operands are still pending watch the shared result bus. When a broadcast carries a matching tag, the entry copies the value.

Once both operands of an entry hold values, the entry is handed to the execution unit, together with its opcode and destination tag. The entry does not leave the bank at that point. It stays occupied until the result bus carries its own destination tag, and only then is its slot returned. A flush input empties the whole bank in one cycle, for example after a mispredicted branch.

The reorder buffer, the tag allocator and the functional unit are outside the block. They appear only as ports: a reorder-slot-available flag, the issue fields, the result bus, and the dispatch outputs.

Top module: `rsb_bank`

## Requirements
- R1: After reset all four entries are free (`has_room` = 1) and `disp_valid` = 0.
- R2: `iss_accept` is 1 only in a cycle where `iss_valid` = 1, `rob_free` = 1, `has_room` = 1 and `flush` = 0. A rejected operation is not stored and is never dispatched.
- R3: An operation accepted in cycle n with both operands marked ready (`iss_a_rdy` = `iss_b_rdy` = 1) appears on the dispatch outputs in cycle n+2. `disp_valid` is high for exactly one cycle, and `disp_op`, `disp_a`, `disp_b` and `disp_dest` equal the issued fields.
- R4: A pending operand is filled when `bc_valid` = 1 and `bc_tag` equals its stored producer tag. A broadcast with any other tag leaves the operand pending. If the other operand already holds a value, the entry dispatches in the second cycle after the matching broadcast, carrying `bc_val` in that operand position.
- R5: If a broadcast occurs in the same cycle as issue and its tag matches an incoming pending operand tag, the operand is captured as a value. The entry then dispatches in cycle n+2, as if the operand had been ready.
- R6: An entry with any operand still pending is never dispatched.
- R7: Issue fills the lowest-index free entry. At most one entry dispatches per cycle. When several entries are ready together, the lowest-index entry goes first, and an entry is dispatched only once.
- R8: An entry stays occupied after dispatch until a broadcast carries its destination tag. With all four entries occupied, `has_room` = 0. It returns to 1 in the cycle after such a freeing broadcast.
- R9: `flush` = 1 for one cycle frees every entry: in the next cycle `has_room` = 1 and `disp_valid` = 0. Operations that were flushed never dispatch, even after a broadcast of their pending tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Free every entry in one cycle |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_a_rdy | input | 1 | Operand A is a value (1) or a producer tag (0) |
| iss_a_val | input | DATA_W | Operand A value |
| iss_a_tag | input | TAG_W | Operand A producer tag |
| iss_b_rdy | input | 1 | Operand B is a value (1) or a producer tag (0) |
| iss_b_val | input | DATA_W | Operand B value |
| iss_b_tag | input | TAG_W | Operand B producer tag |
| iss_dest | input | TAG_W | Reorder-buffer number of the result |
| rob_free | input | 1 | A reorder-buffer slot is available |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_accept | output | 1 | The offered operation is taken this cycle |
| has_room | output | 1 | At least one entry is free |
| disp_valid | output | 1 | Dispatch outputs carry an operation |
| disp_op | output | OP_W | Dispatched opcode |
| disp_a | output | DATA_W | Dispatched operand A |
| disp_b | output | DATA_W | Dispatched operand B |
| disp_dest | output | TAG_W | Dispatched destination tag |

## Verification
`iss_accept` is combinational, so the bench reads it in the issue cycle itself, shortly after driving the inputs. Operand capture and the dispatch pick each take one register stage, so a dispatch shows up two cycles after the issue or the completing broadcast. The bench samples at the falling edge of exactly that cycle, and also checks that the following cycle has no dispatch. A freeing broadcast or a flush shows on `has_room` one cycle later. Tests for "no dispatch" watch the outputs across several cycles after the broadcast that could have woken a flushed or pending entry.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int RSB_ENTRIES = 4;
  localparam int RSB_DATA_W  = 32;
  localparam int RSB_TAG_W   = 4;
  localparam int RSB_OP_W    = 4;
  localparam int RSB_NSRC    = 2;
endpackage

// File: rtl/rsb_pick.sv
// Lowest-index one-hot grant from a request vector.
module rsb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    gnt  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !seen) gnt[i] = 1'b1;
      seen = seen | req[i];
    end
    any = seen;
  end
endmodule

// File: rtl/rsb_operand.sv
// One source operand slot: value or pending tag, with result-bus snoop.
module rsb_operand #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              live,
  input  logic              load,
  input  logic              in_rdy,
  input  logic [DATA_W-1:0] in_val,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic [DATA_W-1:0] val,
  output logic              vld
);
  logic [TAG_W-1:0] tag_q;
  logic             iss_hit;
  logic             snoop_hit;

  // a broadcast in the issue cycle must not be missed
  assign iss_hit   = bc_valid && (bc_tag == in_tag);
  assign snoop_hit = live && !vld && bc_valid && (bc_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst || clr)     vld <= 1'b0;
    else if (load)      vld <= in_rdy || iss_hit;
    else if (snoop_hit) vld <= 1'b1;
  end

  // data path carries no reset
  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= in_tag;
      val   <= in_rdy ? in_val : bc_val;
    end else if (snoop_hit) begin
      val <= bc_val;
    end
  end
endmodule

// File: rtl/rsb_entry.sv
// One station entry: control state plus two operand slots.
module rsb_entry
  import rsb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              grant,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dest,
  input  logic              iss_rdy [RSB_NSRC],
  input  logic [DATA_W-1:0] iss_val [RSB_NSRC],
  input  logic [TAG_W-1:0]  iss_tag [RSB_NSRC],
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              busy,
  output logic              infl,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dest,
  output logic [DATA_W-1:0] src_val [RSB_NSRC]
);
  logic                free_now;
  logic                clr_src;
  logic [RSB_NSRC-1:0] src_vld;

  assign free_now = busy && infl && bc_valid && (bc_tag == dest);
  assign clr_src  = flush || free_now;

  for (genvar k = 0; k < RSB_NSRC; k++) begin : g_src
    rsb_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr_src),
      .live    (busy),
      .load    (load),
      .in_rdy  (iss_rdy[k]),
      .in_val  (iss_val[k]),
      .in_tag  (iss_tag[k]),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_val  (bc_val),
      .val     (src_val[k]),
      .vld     (src_vld[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy <= 1'b0;
      infl <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      infl <= 1'b0;
    end else if (free_now) begin
      busy <= 1'b0;
      infl <= 1'b0;
    end else if (grant) begin
      infl <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op   <= iss_op;
      dest <= iss_dest;
    end
  end

  assign ready = busy && !infl && (&src_vld);
endmodule

// File: rtl/rsb_bank.sv
// Reservation station bank: issue, snoop, lowest-index dispatch.
module rsb_bank
  import rsb_pkg::*;
#(
  parameter int ENTRIES = RSB_ENTRIES,
  parameter int DATA_W  = RSB_DATA_W,
  parameter int TAG_W   = RSB_TAG_W,
  parameter int OP_W    = RSB_OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [TAG_W-1:0]  iss_dest,
  input  logic              rob_free,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              iss_accept,
  output logic              has_room,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_dest
);
  logic [ENTRIES-1:0] busy_q;
  logic [ENTRIES-1:0] infl_q;
  logic [ENTRIES-1:0] ready_v;
  logic [ENTRIES-1:0] alloc_gnt;
  logic [ENTRIES-1:0] disp_gnt;
  logic [ENTRIES-1:0] load_v;
  logic               disp_any;

  logic [OP_W-1:0]    op_e   [ENTRIES];
  logic [TAG_W-1:0]   dest_e [ENTRIES];
  logic [DATA_W-1:0]  src_e  [ENTRIES][RSB_NSRC];

  logic               in_rdy [RSB_NSRC];
  logic [DATA_W-1:0]  in_val [RSB_NSRC];
  logic [TAG_W-1:0]   in_tag [RSB_NSRC];

  assign in_rdy[0] = iss_a_rdy;
  assign in_rdy[1] = iss_b_rdy;
  assign in_val[0] = iss_a_val;
  assign in_val[1] = iss_b_val;
  assign in_tag[0] = iss_a_tag;
  assign in_tag[1] = iss_b_tag;

  // free-slot search; its "any" output is the room flag
  rsb_pick #(.N(ENTRIES)) u_alloc (
    .req(~busy_q),
    .gnt(alloc_gnt),
    .any(has_room)
  );

  assign iss_accept = iss_valid && rob_free && has_room && !flush;
  assign load_v     = alloc_gnt & {ENTRIES{iss_accept}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    rsb_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .load    (load_v[i]),
      .grant   (disp_gnt[i]),
      .iss_op  (iss_op),
      .iss_dest(iss_dest),
      .iss_rdy (in_rdy),
      .iss_val (in_val),
      .iss_tag (in_tag),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_val  (bc_val),
      .busy    (busy_q[i]),
      .infl    (infl_q[i]),
      .ready   (ready_v[i]),
      .op      (op_e[i]),
      .dest    (dest_e[i]),
      .src_val (src_e[i])
    );
  end

  rsb_pick #(.N(ENTRIES)) u_disp (
    .req(ready_v),
    .gnt(disp_gnt),
    .any(disp_any)
  );

  // AND-OR selection of the granted entry
  logic [OP_W-1:0]   mux_op;
  logic [TAG_W-1:0]  mux_dest;
  logic [DATA_W-1:0] mux_a;
  logic [DATA_W-1:0] mux_b;

  always_comb begin
    mux_op   = '0;
    mux_dest = '0;
    mux_a    = '0;
    mux_b    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (disp_gnt[i]) begin
        mux_op   = mux_op   | op_e[i];
        mux_dest = mux_dest | dest_e[i];
        mux_a    = mux_a    | src_e[i][0];
        mux_b    = mux_b    | src_e[i][1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) disp_valid <= 1'b0;
    else              disp_valid <= disp_any;
  end

  always_ff @(posedge clk) begin
    if (disp_any) begin
      disp_op   <= mux_op;
      disp_dest <= mux_dest;
      disp_a    <= mux_a;
      disp_b    <= mux_b;
    end
  end
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               rob_free,
  input logic               iss_accept,
  input logic               has_room,
  input logic               disp_valid,
  input logic [TAG_W-1:0]   disp_dest,
  input logic [ENTRIES-1:0] busy_q,
  input logic [ENTRIES-1:0] infl_q,
  input logic [ENTRIES-1:0] disp_gnt
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (has_room && !disp_valid));

  // R2
  no_accept_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!has_room || !rob_free) |-> !iss_accept);

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(disp_gnt));

  // R7
  no_regrant_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_gnt & infl_q) == '0);

  // R3
  grant_to_output_chk: assert property (@(posedge clk) disable iff (rst)
    ((|disp_gnt) && !flush) |=> disp_valid);

  // R7
  no_double_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && $past(disp_valid)) |-> (disp_dest != $past(disp_dest)));

  // R8
  infl_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (infl_q & ~busy_q) == '0);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (has_room && !disp_valid && busy_q == '0));
endmodule

bind rsb_bank rsb_bank_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .rob_free  (rob_free),
  .iss_accept(iss_accept),
  .has_room  (has_room),
  .disp_valid(disp_valid),
  .disp_dest (disp_dest),
  .busy_q    (busy_q),
  .infl_q    (infl_q),
  .disp_gnt  (disp_gnt)
);

// File: tb/rsb_bank_tb.sv
module rsb_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush;
  logic        iss_valid;
  logic [3:0]  iss_op;
  logic        iss_a_rdy, iss_b_rdy;
  logic [31:0] iss_a_val, iss_b_val;
  logic [3:0]  iss_a_tag, iss_b_tag, iss_dest;
  logic        rob_free;
  logic        bc_valid;
  logic [3:0]  bc_tag;
  logic [31:0] bc_val;
  logic        iss_accept, has_room, disp_valid;
  logic [3:0]  disp_op, disp_dest;
  logic [31:0] disp_a, disp_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rsb_bank u_dut (
    .clk(clk), .rst(rst), .flush(flush), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .iss_dest(iss_dest), .rob_free(rob_free), .bc_valid(bc_valid),
    .bc_tag(bc_tag), .bc_val(bc_val), .iss_accept(iss_accept),
    .has_room(has_room), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_dest(disp_dest)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; iss_valid = 0; iss_op = 0;
    iss_a_rdy = 0; iss_a_val = 0; iss_a_tag = 0;
    iss_b_rdy = 0; iss_b_val = 0; iss_b_tag = 0;
    iss_dest = 0; rob_free = 1; bc_valid = 0; bc_tag = 0; bc_val = 0;
  endtask

  task automatic drive_issue(logic [3:0] op, logic ar, logic [31:0] av, logic [3:0] at,
                             logic br, logic [31:0] bv, logic [3:0] bt, logic [3:0] dst);
    iss_valid = 1; iss_op = op;
    iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
    iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
    iss_dest = dst;
  endtask

  task automatic bcast(logic [3:0] t, logic [31:0] v);
    bc_valid = 1; bc_tag = t; bc_val = v;
    step();
    bc_valid = 0;
  endtask

  task automatic expect_disp(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [3:0] dst);
    check({req, " disp_valid"}, disp_valid, 1);
    check({req, " disp_op"}, disp_op, op);
    check({req, " disp_a"}, disp_a, a);
    check({req, " disp_b"}, disp_b, b);
    check({req, " disp_dest"}, disp_dest, dst);
  endtask

  task automatic t_reset();
    check("R1 has_room", has_room, 1);
    check("R1 disp_valid", disp_valid, 0);
  endtask

  task automatic t_ready_issue();
    drive_issue(4'd3, 1, 32'd10, 0, 1, 32'd20, 0, 4'd5);
    #1 check("R2 accept", iss_accept, 1);
    step(); idle();
    check("R3 not early", disp_valid, 0);
    step();
    expect_disp("R3", 4'd3, 32'd10, 32'd20, 4'd5);
    step();
    check("R3 one-cycle pulse", disp_valid, 0);
    bcast(4'd5, 32'd0);
  endtask

  task automatic t_snoop();
    drive_issue(4'd6, 1, 32'd11, 0, 0, 0, 4'd7, 4'd6);
    step(); idle();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R6 pending holds", disp_valid, 0);
    end
    bcast(4'd3, 32'd33);
    step();
    check("R4 other tag ignored", disp_valid, 0);
    step();
    check("R4 other tag ignored", disp_valid, 0);
    bcast(4'd7, 32'd77);
    check("R4 not early", disp_valid, 0);
    step();
    expect_disp("R4", 4'd6, 32'd11, 32'd77, 4'd6);
    bcast(4'd6, 32'd0);
  endtask

  task automatic t_bypass();
    drive_issue(4'd9, 0, 0, 4'd9, 1, 32'd22, 0, 4'd8);
    bc_valid = 1; bc_tag = 4'd9; bc_val = 32'd99;
    step(); idle();
    step();
    expect_disp("R5", 4'd9, 32'd99, 32'd22, 4'd8);
    bcast(4'd8, 32'd0);
  endtask

  task automatic t_priority();
    for (int i = 1; i <= 3; i++) begin
      drive_issue(4'(i), 1, 32'(100 + i), 0, 0, 0, 4'd12, 4'(i));
      step();
    end
    idle();
    step();
    check("R6 all pending", disp_valid, 0);
    bcast(4'd12, 32'd5);
    step();
    expect_disp("R7 first", 4'd1, 32'd101, 32'd5, 4'd1);
    step();
    expect_disp("R7 second", 4'd2, 32'd102, 32'd5, 4'd2);
    step();
    expect_disp("R7 third", 4'd3, 32'd103, 32'd5, 4'd3);
    step();
    check("R7 no repeat", disp_valid, 0);
    for (int i = 1; i <= 3; i++) bcast(4'(i), 32'd0);
  endtask

  task automatic t_capacity();
    for (int i = 1; i <= 4; i++) begin
      drive_issue(4'd2, 1, 32'd1, 0, 1, 32'd2, 0, 4'(i));
      step();
    end
    idle();
    check("R8 full", has_room, 0);
    drive_issue(4'd14, 1, 32'd5, 0, 1, 32'd6, 0, 4'd9);
    #1 check("R2 reject when full", iss_accept, 0);
    step(); idle();
    for (int i = 0; i < 6; i++) step();
    check("R8 held after dispatch", has_room, 0);
    check("R2 rejected never dispatched", disp_valid, 0);
    bcast(4'd2, 32'd0);
    check("R8 freed", has_room, 1);
    bcast(4'd1, 32'd0);
    bcast(4'd3, 32'd0);
    bcast(4'd4, 32'd0);
  endtask

  task automatic t_rob_block();
    rob_free = 0;
    drive_issue(4'd15, 1, 32'd3, 0, 1, 32'd4, 0, 4'd10);
    #1 check("R2 rob busy reject", iss_accept, 0);
    step(); idle();
    step();
    check("R2 rejected not dispatched", disp_valid, 0);
    step();
    check("R2 rejected not dispatched", disp_valid, 0);
  endtask

  task automatic t_flush();
    for (int i = 1; i <= 4; i++) begin
      drive_issue(4'd4, 0, 0, 4'd13, 1, 32'd8, 0, 4'(i));
      step();
    end
    idle();
    check("R9 precondition full", has_room, 0);
    flush = 1;
    drive_issue(4'd5, 1, 32'd1, 0, 1, 32'd1, 0, 4'd11);
    #1 check("R2 no accept in flush", iss_accept, 0);
    step(); idle();
    check("R9 room after flush", has_room, 1);
    check("R9 no dispatch", disp_valid, 0);
    bcast(4'd13, 32'd44);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R9 flushed stays gone", disp_valid, 0);
    end
    drive_issue(4'd7, 1, 32'd70, 0, 1, 32'd71, 0, 4'd12);
    step(); idle();
    step();
    expect_disp("R3 after flush", 4'd7, 32'd70, 32'd71, 4'd12);
    bcast(4'd12, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_ready_issue();
    t_snoop();
    t_bypass();
    t_priority();
    t_capacity();
    t_rob_block();
    t_flush();
    repeat (2) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule